// File: doc/BRIEF.md
# DAC data register update controller

This block is the digital front end of a single 12-bit voltage-output converter channel. Software reaches it through a byte-wide register port with three locations: a low data byte, a high data byte and a configuration byte. The low byte goes into a hidden holding register. The 12-bit code is assembled only when the high byte is written, and it lands in a staging register. The code is aligned either to the right or to the left of the 16 bits formed by the two bytes.

The staged code moves to the output code register only when the selected update trigger fires. The trigger can be every clock, a pulse from one of three timer overflow lines, or a rising edge on one of four logic inputs. An inhibit bit holds back all updates. Several channels that share one trigger can therefore be loaded one after another and then released together. A keep bit lets the code and configuration survive a system reset. Only a power-on reset clears them unconditionally.

Top module: `dac_code_stager`

## Requirements
- R1: With the justify bit (config bit 1) at 0, a high-byte write stages code[11:8] = high[3:0] and code[7:0] = the held low byte. The upper nibble of the high byte is not used.
- R2: With the justify bit at 1, a high-byte write stages code[11:4] = high[7:0] and code[3:0] = bits 7:4 of the held low byte.
- R3: A low-byte write (address 0) changes only the holding register. The staged code changes only on a high-byte write (address 1), so a trigger between the two writes commits the previous complete code.
- R4: With trigger select (config bits 6:4) at 0, the output code takes the new value one clock after the clock edge that writes the high byte.
- R5: Trigger select values 1, 2 and 3 commit the staged code on a single-cycle pulse of overflow input 0, 1 or 2 respectively. Pulses on the other overflow lines are ignored.
- R6: Trigger select values 4 to 7 commit on a rising edge of logic input 0 to 3 respectively. A level held high commits only once.
- R7: While the inhibit bit (config bit 2) is 1, the output code does not change. After the bit is cleared, the staged code is applied on the next trigger event.
- R8: The `updated` output is high for exactly one cycle after each clock edge on which a trigger commits the staged code, and low otherwise.
- R9: After power-on reset, the output code is 0 and the configuration is 0: the channel is disabled, the trigger is every clock and the code is right-justified.
- R10: The enable bit (config bit 0) drives `chanEn` and nothing else. A disabled channel still accepts writes and updates its code.
- R11: A system reset with the keep bit (config bit 3) at 0 clears the code, the staged data and the configuration. With the keep bit at 1, the code, the staged data, the high byte and the configuration persist, and only the holding low byte is cleared.
- R12: The read port returns the holding low byte at address 0, the last high byte at address 1, the configuration at address 2 (bit 7 reads 0) and 0 at address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstPorN | input | 1 | Power-on reset, asynchronous, active low |
| rstSysN | input | 1 | System reset, synchronous, active low, governed by the keep bit |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address: 0 low, 1 high, 2 config |
| wrData | input | 8 | Write data byte |
| rdAddr | input | 2 | Read address |
| rdData | output | 8 | Read data, combinational |
| timerOvf | input | 3 | Timer overflow pulses, one cycle each |
| logicIn | input | 4 | Logic-level trigger inputs, rising edge used |
| codeOut | output | 12 | Committed converter code |
| chanEn | output | 1 | Channel enable |
| updated | output | 1 | One-cycle strobe after a commit |

## Verification
The bench stages a code with a low-byte write only and then fires a trigger. A design that updates the staged code on the low write would commit a half-formed value there. It holds a logic input high across several cycles, where a level-sensitive trigger would commit each new staged code. It pulses the timer lines that are not selected, and a wrong select decode would let them commit. It clears the inhibit bit and counts the cycle in which the pending code appears. It checks a system reset with the keep bit both set and clear, which exposes a design that ignores the keep bit or forgets to clear the holding byte.

// File: rtl/dac_stage_pkg.sv
package dac_stage_pkg;

  localparam logic [1:0] ADDR_LOW  = 2'd0;
  localparam logic [1:0] ADDR_HIGH = 2'd1;
  localparam logic [1:0] ADDR_CFG  = 2'd2;

  localparam int CFG_EN     = 0;
  localparam int CFG_LEFT   = 1;
  localparam int CFG_INH    = 2;
  localparam int CFG_KEEP   = 3;
  localparam int CFG_SEL_LO = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic loadLow;
    logic loadHigh;
    logic commit;
    logic clrAll;
    logic clrHold;
  } stageCtl_t;

endpackage

// File: rtl/dac_stage_trig.sv
module dac_stage_trig #(
  parameter int NUM_TIMERS = 3,
  parameter int NUM_LOGIC  = 4,
  parameter int SEL_W      = 3
) (
  input  logic                  clk,
  input  logic                  rstPorN,
  input  logic                  rstSysN,
  input  logic [NUM_TIMERS-1:0] timerOvf,
  input  logic [NUM_LOGIC-1:0]  logicIn,
  input  logic [SEL_W-1:0]      trigSel,
  output logic                  trigHit
);

  localparam int NSRC     = 1 + NUM_TIMERS + NUM_LOGIC;
  localparam int SRC_SPAN = 1 << SEL_W;

  logic [NUM_LOGIC-1:0] riseHit;
  logic [SRC_SPAN-1:0]  srcVec;

  generate
    for (genvar j = 0; j < NUM_LOGIC; j++) begin : g_edge
      logic prevLvl;
      // history starts high so a level already high at reset is not an edge
      always_ff @(posedge clk or negedge rstPorN) begin
        if (!rstPorN)      prevLvl <= 1'b1;
        else if (!rstSysN) prevLvl <= 1'b1;
        else               prevLvl <= logicIn[j];
      end
      assign riseHit[j] = logicIn[j] & ~prevLvl;

      // R6: an edge yields a single-cycle pulse
      assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rstPorN)
        riseHit[j] |=> !riseHit[j]);
    end
  endgenerate

  always_comb begin
    srcVec = '0;
    srcVec[NSRC-1:0] = {riseHit, timerOvf, 1'b1};
    trigHit = srcVec[trigSel];
  end

endmodule

// File: rtl/dac_stage_ctrl.sv
module dac_stage_ctrl
  import dac_stage_pkg::*;
#(
  parameter int SEL_W = 3,
  parameter int CFG_W = 4 + SEL_W
) (
  input  logic             clk,
  input  logic             rstPorN,
  input  logic             rstSysN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CFG_W-1:0] cfgData,
  input  logic             trigHit,
  output logic [SEL_W-1:0] trigSel,
  output logic             cfgEn,
  output logic             cfgLeft,
  output logic [CFG_W-1:0] cfgByte,
  output stageCtl_t        ctl
);

  logic cfgInh;
  logic cfgKeep;
  logic cfgWrite;

  assign cfgWrite = wrEn && (wrAddr == ADDR_CFG);

  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN) begin
      cfgEn   <= 1'b0;
      cfgLeft <= 1'b0;
      cfgInh  <= 1'b0;
      cfgKeep <= 1'b0;
      trigSel <= '0;
    end else if (!rstSysN) begin
      if (!cfgKeep) begin
        cfgEn   <= 1'b0;
        cfgLeft <= 1'b0;
        cfgInh  <= 1'b0;
        trigSel <= '0;
      end
    end else if (cfgWrite) begin
      cfgEn   <= cfgData[CFG_EN];
      cfgLeft <= cfgData[CFG_LEFT];
      cfgInh  <= cfgData[CFG_INH];
      cfgKeep <= cfgData[CFG_KEEP];
      trigSel <= cfgData[CFG_SEL_LO +: SEL_W];
    end
  end

  always_comb begin
    cfgByte = '0;
    cfgByte[CFG_EN]   = cfgEn;
    cfgByte[CFG_LEFT] = cfgLeft;
    cfgByte[CFG_INH]  = cfgInh;
    cfgByte[CFG_KEEP] = cfgKeep;
    cfgByte[CFG_SEL_LO +: SEL_W] = trigSel;
  end

  always_comb begin
    ctl.loadLow  = rstSysN && wrEn && (wrAddr == ADDR_LOW);
    ctl.loadHigh = rstSysN && wrEn && (wrAddr == ADDR_HIGH);
    ctl.commit   = rstSysN && trigHit && !cfgInh;
    ctl.clrAll   = !rstSysN && !cfgKeep;
    ctl.clrHold  = !rstSysN;
  end

  // R7: no commit is issued while inhibited
  assert_inhibit_blocks_R7: assert property (@(posedge clk) disable iff (!rstPorN)
    cfgInh |-> !ctl.commit);

  // R11: a system reset without the keep bit wipes the configuration
  assert_sysreset_clears_R11: assert property (@(posedge clk) disable iff (!rstPorN)
    (!rstSysN && !cfgKeep) |=> (cfgByte == '0));

endmodule

// File: rtl/dac_stage_data.sv
module dac_stage_data
  import dac_stage_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstPorN,
  input  logic              rstSysN,
  input  stageCtl_t         ctl,
  input  logic              leftJust,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] holdLow,
  output logic [BYTE_W-1:0] highByte,
  output logic [CODE_W-1:0] codeOut,
  output logic              updated
);

  localparam int NIB = CODE_W - BYTE_W;

  logic [CODE_W-1:0] staged;
  logic [CODE_W-1:0] assembled;

  always_comb begin
    if (leftJust) assembled = {wrData, holdLow[BYTE_W-1 -: NIB]};
    else          assembled = {wrData[NIB-1:0], holdLow};
  end

  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN) begin
      holdLow  <= '0;
      highByte <= '0;
      staged   <= '0;
      codeOut  <= '0;
      updated  <= 1'b0;
    end else if (ctl.clrAll) begin
      holdLow  <= '0;
      highByte <= '0;
      staged   <= '0;
      codeOut  <= '0;
      updated  <= 1'b0;
    end else if (ctl.clrHold) begin
      holdLow  <= '0;
      updated  <= 1'b0;
    end else begin
      if (ctl.loadLow) holdLow <= wrData;
      if (ctl.loadHigh) begin
        highByte <= wrData;
        staged   <= assembled;
      end
      if (ctl.commit) codeOut <= staged;
      updated <= ctl.commit;
    end
  end

  // R5: a commit moves the staged code to the output
  assert_commit_takes_staged_R5: assert property (@(posedge clk) disable iff (!rstPorN)
    ctl.commit |=> (codeOut == $past(staged)));

  // R7: without a commit the output code holds
  assert_code_holds_R7: assert property (@(posedge clk) disable iff (!rstPorN)
    (rstSysN && !ctl.commit) |=> $stable(codeOut));

  // R3: a low-byte write alone leaves the staged code untouched
  assert_low_only_R3: assert property (@(posedge clk) disable iff (!rstPorN)
    (ctl.loadLow && !ctl.loadHigh) |=> $stable(staged));

endmodule

// File: rtl/dac_code_stager.sv
module dac_code_stager
  import dac_stage_pkg::*;
#(
  parameter int CODE_W     = 12,
  parameter int BYTE_W     = 8,
  parameter int NUM_TIMERS = 3,
  parameter int NUM_LOGIC  = 4
) (
  input  logic                  clk,
  input  logic                  rstPorN,
  input  logic                  rstSysN,
  input  logic                  wrEn,
  input  logic [1:0]            wrAddr,
  input  logic [BYTE_W-1:0]     wrData,
  input  logic [1:0]            rdAddr,
  output logic [BYTE_W-1:0]     rdData,
  input  logic [NUM_TIMERS-1:0] timerOvf,
  input  logic [NUM_LOGIC-1:0]  logicIn,
  output logic [CODE_W-1:0]     codeOut,
  output logic                  chanEn,
  output logic                  updated
);

  localparam int NSRC  = 1 + NUM_TIMERS + NUM_LOGIC;
  localparam int SEL_W = $clog2(NSRC);
  localparam int CFG_W = 4 + SEL_W;

  stageCtl_t         ctl;
  logic [SEL_W-1:0]  trigSel;
  logic              trigHit;
  logic              cfgLeft;
  logic [CFG_W-1:0]  cfgByte;
  logic [BYTE_W-1:0] holdLow;
  logic [BYTE_W-1:0] highByte;

  dac_stage_trig #(
    .NUM_TIMERS(NUM_TIMERS),
    .NUM_LOGIC (NUM_LOGIC),
    .SEL_W     (SEL_W)
  ) u_trig (
    .clk     (clk),
    .rstPorN (rstPorN),
    .rstSysN (rstSysN),
    .timerOvf(timerOvf),
    .logicIn (logicIn),
    .trigSel (trigSel),
    .trigHit (trigHit)
  );

  dac_stage_ctrl #(
    .SEL_W(SEL_W),
    .CFG_W(CFG_W)
  ) u_ctrl (
    .clk    (clk),
    .rstPorN(rstPorN),
    .rstSysN(rstSysN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .cfgData(wrData[CFG_W-1:0]),
    .trigHit(trigHit),
    .trigSel(trigSel),
    .cfgEn  (chanEn),
    .cfgLeft(cfgLeft),
    .cfgByte(cfgByte),
    .ctl    (ctl)
  );

  dac_stage_data #(
    .CODE_W(CODE_W),
    .BYTE_W(BYTE_W)
  ) u_data (
    .clk     (clk),
    .rstPorN (rstPorN),
    .rstSysN (rstSysN),
    .ctl     (ctl),
    .leftJust(cfgLeft),
    .wrData  (wrData),
    .holdLow (holdLow),
    .highByte(highByte),
    .codeOut (codeOut),
    .updated (updated)
  );

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADDR_LOW:  rdData = holdLow;
      ADDR_HIGH: rdData = highByte;
      ADDR_CFG:  rdData[CFG_W-1:0] = cfgByte;
      default:   rdData = '0;
    endcase
  end

  // R8: the strobe never lasts past a cycle without a fresh commit
  assert_strobe_follows_R8: assert property (@(posedge clk) disable iff (!rstPorN)
    (rstSysN && !trigHit) |=> !updated);

endmodule

// File: tb/test_dac_code_stager.sv
module test_dac_code_stager;

  logic        clk = 1'b0;
  logic        rstPorN = 1'b0;
  logic        rstSysN = 1'b1;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic [1:0]  rdAddr = '0;
  logic [7:0]  rdData;
  logic [2:0]  timerOvf = '0;
  logic [3:0]  logicIn = '0;
  logic [11:0] codeOut;
  logic        chanEn;
  logic        updated;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit monOn = 0;
  logic [11:0] expQ[$];
  logic [11:0] lastCode = '0;

  always #2.5 clk = ~clk;

  dac_code_stager i_dac_code_stager (
    .clk(clk), .rstPorN(rstPorN), .rstSysN(rstSysN),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData),
    .timerOvf(timerOvf), .logicIn(logicIn),
    .codeOut(codeOut), .chanEn(chanEn), .updated(updated)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulseTimer(input int idx);
    @(negedge clk);
    timerOvf[idx] = 1'b1;
    @(negedge clk);
    timerOvf = '0;
  endtask

  task automatic sysReset();
    @(negedge clk);
    rstSysN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstSysN = 1'b1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    rdAddr = a;
    #0.5;
    v = rdData;
  endtask

  // monitor: every change of the output code must match the next expected item
  initial begin
    forever begin
      @(negedge clk);
      if (monOn && codeOut !== lastCode) begin
        if (expQ.size() == 0) begin
          checks++; errors++;
          $display("FAIL scoreboard R5 actual=%0h expected=none", codeOut);
        end else begin
          check("scoreboard R4", int'(codeOut), int'(expQ.pop_front()));
        end
        lastCode = codeOut;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstPorN = 1'b1;
    // R9 reset state
    check("R9 code after power-on", int'(codeOut), 0);
    check("R9 enable after power-on", int'(chanEn), 0);
    rd(2'd2, v);
    check("R9 config after power-on", int'(v), 0);
    monOn = 1;

    // R1 right justified, every-clock trigger
    expQ.push_back(12'h75A);
    wr(2'd0, 8'h5A);
    wr(2'd1, 8'hF7);
    check("R4 code not yet updated", int'(codeOut), 0);
    @(negedge clk);
    check("R1 right justified code", int'(codeOut), 'h75A);
    check("R8 strobe after commit", int'(updated), 1);

    // R2 left justified
    wr(2'd2, 8'h02);
    expQ.push_back(12'h3CA);
    wr(2'd0, 8'hA5);
    wr(2'd1, 8'h3C);
    @(negedge clk);
    check("R2 left justified code", int'(codeOut), 'h3CA);

    // R5 timer 0 trigger, right justified
    wr(2'd2, 8'h10);
    wr(2'd0, 8'h34);
    wr(2'd1, 8'h12);
    repeat (2) @(negedge clk);
    check("R5 waits for timer", int'(codeOut), 'h3CA);
    check("R8 strobe idle", int'(updated), 0);
    pulseTimer(1);
    check("R5 other timer ignored", int'(codeOut), 'h3CA);
    check("R8 no strobe on ignored pulse", int'(updated), 0);
    expQ.push_back(12'h234);
    pulseTimer(0);
    check("R5 timer commit", int'(codeOut), 'h234);
    check("R8 strobe on timer commit", int'(updated), 1);
    @(negedge clk);
    check("R8 strobe single cycle", int'(updated), 0);

    // R3 low byte only, then trigger
    wr(2'd0, 8'h99);
    pulseTimer(0);
    check("R3 half write not committed", int'(codeOut), 'h234);
    check("R3 trigger still strobes", int'(updated), 1);
    expQ.push_back(12'h199);
    wr(2'd1, 8'h01);
    pulseTimer(0);
    check("R3 full write committed", int'(codeOut), 'h199);

    // R6 logic input 2 rising edge
    wr(2'd2, 8'h60);
    expQ.push_back(12'h811);
    wr(2'd0, 8'h11);
    wr(2'd1, 8'h08);
    @(negedge clk);
    logicIn[2] = 1'b1;
    @(negedge clk);
    check("R6 rising edge commit", int'(codeOut), 'h811);
    check("R8 strobe on edge", int'(updated), 1);
    @(negedge clk);
    check("R6 held level no strobe", int'(updated), 0);
    wr(2'd0, 8'h22);
    wr(2'd1, 8'h08);
    repeat (3) @(negedge clk);
    check("R6 held level no commit", int'(codeOut), 'h811);
    logicIn[2] = 1'b0;
    @(negedge clk);
    expQ.push_back(12'h822);
    logicIn[2] = 1'b1;
    @(negedge clk);
    check("R6 second edge commit", int'(codeOut), 'h822);
    logicIn = '0;

    // R7 inhibit with every-clock trigger
    wr(2'd2, 8'h04);
    wr(2'd0, 8'h56);
    wr(2'd1, 8'h04);
    repeat (3) @(negedge clk);
    check("R7 inhibit holds code", int'(codeOut), 'h822);
    check("R7 inhibit no strobe", int'(updated), 0);
    expQ.push_back(12'h456);
    wr(2'd2, 8'h00);
    check("R7 not before next trigger", int'(codeOut), 'h822);
    @(negedge clk);
    check("R7 release commits", int'(codeOut), 'h456);

    // R10 enable, R12 read back
    wr(2'd2, 8'h09);
    check("R10 enable output", int'(chanEn), 1);
    rd(2'd2, v); check("R12 config read", int'(v), 'h09);
    rd(2'd1, v); check("R12 high byte read", int'(v), 'h04);
    rd(2'd0, v); check("R12 low byte read", int'(v), 'h56);
    rd(2'd3, v); check("R12 unused address", int'(v), 0);

    // R11 system reset with keep
    sysReset();
    @(negedge clk);
    check("R11 keep code", int'(codeOut), 'h456);
    check("R11 keep enable", int'(chanEn), 1);
    rd(2'd2, v); check("R11 keep config", int'(v), 'h09);
    rd(2'd0, v); check("R11 holding cleared", int'(v), 0);
    rd(2'd1, v); check("R11 keep high byte", int'(v), 'h04);

    // R11 system reset without keep
    wr(2'd2, 8'h01);
    expQ.push_back(12'h000);
    sysReset();
    check("R11 code cleared", int'(codeOut), 0);
    check("R11 enable cleared", int'(chanEn), 0);
    rd(2'd2, v); check("R11 config cleared", int'(v), 0);
    rd(2'd1, v); check("R11 high byte cleared", int'(v), 0);

    // R10 disabled channel still updates
    expQ.push_back(12'hABC);
    wr(2'd0, 8'hBC);
    wr(2'd1, 8'h0A);
    @(negedge clk);
    check("R10 disabled still updates", int'(codeOut), 'hABC);
    check("R10 enable stays low", int'(chanEn), 0);

    repeat (3) @(negedge clk);
    check("R5 scoreboard drained", expQ.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule